// File: doc/BRIEF.md
# Multiplexed External Memory Bus Bridge

The bridge turns single transfers from an on-chip request port into cycles on an 8-bit external memory bus. On that bus, the low address byte and the data byte share one set of pins. The high address byte has pins of its own. Each external cycle begins with an address phase. In that phase the low address byte is driven on the shared pins and the address latch enable is high, so a transparent latch on the board can hold the byte. The latch enable then falls. After that the data phase runs under an active-low read strobe or an active-low write strobe.

The shared pins are modelled with three signals: an output value, an output enable and an input value. An enable of zero means the pins are released to high impedance. The data phase can be stretched by wait cycles. The number of wait cycles depends on the sector that the address falls in. A 3-bit limit input splits external space into a lower sector and an upper sector. Each sector has its own 2-bit wait select. Addresses under 0x1100 are not external: they complete without any bus cycle.

Top module: `xmem_bridge`

## Requirements
- R1: After reset, `ale` is low, `rd_n` and `wr_n` are high, `ad_oe` is low and `req_ack` is low.
- R2: In the cycle after a request is accepted, `ale` is high for exactly one cycle. During that cycle, `ad_oe` is high, `ad_o` carries address bits 7:0, `a_hi` carries address bits 15:8, and both strobes are high.
- R3: The strobe goes low in the cycle right after the `ale` cycle. A write drives `wr_n` low with `ad_oe` high and the write byte on `ad_o`. A read drives `rd_n` low with `ad_oe` low. Both strobes are never low together.
- R4: The wait select sets how many cycles the strobe stays low. 00 gives 1 cycle, 01 gives 2 cycles and 10 gives 3 cycles. 11 gives 3 cycles followed by one hold cycle, in which both strobes are high, `ad_oe` is low and `a_hi` is unchanged.
- R5: With a limit of 0, every external address uses the lower-sector select. With a limit L from 1 to 7, an address at or above L×0x2000 uses the upper-sector select and any lower address uses the lower-sector select.
- R6: A read captures `ad_i` on the final strobe-low cycle. That byte appears on `req_rdata` while `req_ack` is high.
- R7: `req_ack` is high for exactly one cycle. That cycle directly follows the last strobe-low cycle, or the hold cycle when there is one. During it, both strobes are high and `ale` is low.
- R8: A request is accepted only while the bridge is idle. If a request is raised during the `req_ack` cycle, one idle cycle follows, and `ale` rises in the cycle after that.
- R9: An address below 0x1100 (0x1100 itself is external) produces no `ale` and no strobe. `req_ack` rises in the cycle after acceptance, and a read returns 0x00.
- R10: `a_hi` does not change from the `ale` cycle to the end of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read byte, valid with ack |
| cfg_limit | input | 3 | Sector split setting |
| cfg_wait_lo | input | 2 | Lower-sector wait select |
| cfg_wait_hi | input | 2 | Upper-sector wait select |
| ad_o | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus input value |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Completion and acceptance of a new request can fall in the same cycle. This happens when the next request is raised during the ack pulse. The bench does this back to back and expects exactly one idle cycle before the next `ale`, with no strobe or `ale` during the ack cycle. Read sampling and the end of the strobe also coincide. To judge that, the bench changes `ad_i` in every strobe cycle and expects the byte that was present in the last one.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int WSEL_W = 2;
  localparam int TMR_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } xm_state_e;

  // number of extra strobe-low cycles for a wait select
  function automatic logic [TMR_W-1:0] wait_extra(input logic [WSEL_W-1:0] code);
    logic [TMR_W-1:0] v;
    case (code)
      2'b00:   v = 2'd0;
      2'b01:   v = 2'd1;
      default: v = 2'd2;
    endcase
    return v;
  endfunction

  function automatic logic wants_hold(input logic [WSEL_W-1:0] code);
    return code == 2'b11;
  endfunction
endpackage

// File: rtl/xmem_rst_sync.sv
module xmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel #(
  parameter int                ADDR_W   = 16,
  parameter int                LIMIT_W  = 3,
  parameter int                WSEL_W   = 2,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h1100
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [WSEL_W-1:0]  wait_lo,
  input  logic [WSEL_W-1:0]  wait_hi,
  output logic               is_ext,
  output logic [WSEL_W-1:0]  wsel
);
  localparam int SHIFT = ADDR_W - LIMIT_W;

  logic [ADDR_W-1:0] boundary;
  logic              upper;

  always_comb begin
    boundary = {limit, {SHIFT{1'b0}}};
    upper    = (limit != '0) && (addr >= boundary);
    is_ext   = addr >= EXT_BASE;
    wsel     = upper ? wait_hi : wait_lo;
  end
endmodule

// File: rtl/xmem_wait_timer.sv
module xmem_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (run && cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = cnt_q == '0;
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
  import xmem_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                LIMIT_W  = 3,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h1100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [DATA_W-1:0]   req_rdata,
  input  logic [LIMIT_W-1:0]  cfg_limit,
  input  logic [WSEL_W-1:0]   cfg_wait_lo,
  input  logic [WSEL_W-1:0]   cfg_wait_hi,
  output logic [DATA_W-1:0]   ad_o,
  output logic                ad_oe,
  input  logic [DATA_W-1:0]   ad_i,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              rst_n_s;
  xm_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              sel_ext;
  logic [WSEL_W-1:0] sel_wsel;
  logic              cap_en, smp_en;
  logic              tmr_load, tmr_run, tmr_zero;

  xmem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  xmem_sector_sel #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .WSEL_W(WSEL_W), .EXT_BASE(EXT_BASE)
  ) u_sel (
    .addr(req_addr), .limit(cfg_limit), .wait_lo(cfg_wait_lo),
    .wait_hi(cfg_wait_hi), .is_ext(sel_ext), .wsel(sel_wsel)
  );

  xmem_wait_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load),
    .load_val(wait_extra(wsel_q)), .run(tmr_run), .zero(tmr_zero)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = sel_ext ? ST_ADDR : ST_DONE;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: if (tmr_zero) state_d = wants_hold(wsel_q) ? ST_HOLD : ST_DONE;
      ST_HOLD: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cap_en   = (state_q == ST_IDLE) && req_valid;
    smp_en   = (state_q == ST_STRB) && tmr_zero && !write_q;
    tmr_load = state_q == ST_ADDR;
    tmr_run  = state_q == ST_STRB;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      wsel_q  <= '0;
    end else if (cap_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      wsel_q  <= sel_wsel;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdata_q <= '0;
    else if (cap_en) rdata_q <= '0;
    else if (smp_en) rdata_q <= ad_i;
  end

  // bus outputs decoded from state
  always_comb begin
    ale   = state_q == ST_ADDR;
    ad_oe = (state_q == ST_ADDR) || ((state_q == ST_STRB) && write_q);
    if (state_q == ST_ADDR)  ad_o = addr_q[DATA_W-1:0];
    else if (ad_oe)          ad_o = wdata_q;
    else                     ad_o = '0;
    rd_n  = !((state_q == ST_STRB) && !write_q);
    wr_n  = !((state_q == ST_STRB) && write_q);
    a_hi  = addr_q[ADDR_W-1 -: HI_W];
    req_ack   = state_q == ST_DONE;
    req_rdata = rdata_q;
  end
endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ack,
  input logic       ad_oe,
  input logic [7:0] a_hi,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n
);
  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R2
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(ale)); // R3
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R7
  AST_ACK_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (rd_n && wr_n && !ale)); // R7
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(a_hi)); // R10
endmodule

bind xmem_bridge xmem_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .ad_oe(ad_oe),
  .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/xmem_bridge_bench.sv
module xmem_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack;
  logic [7:0]  req_rdata;
  logic [2:0]  cfg_limit = '0;
  logic [1:0]  cfg_wait_lo = '0, cfg_wait_hi = '0;
  logic [7:0]  ad_o, ad_i = '0, a_hi;
  logic        ad_oe, ale, rd_n, wr_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xmem_bridge u_xmem_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .req_rdata(req_rdata), .cfg_limit(cfg_limit), .cfg_wait_lo(cfg_wait_lo),
    .cfg_wait_hi(cfg_wait_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic bus(input string tag, input bit e_ale, input bit e_rd_n,
                     input bit e_wr_n, input bit e_oe, input bit e_ack);
    chk(ale == e_ale, tag, "ale", ale, e_ale);
    chk(rd_n == e_rd_n, tag, "rd_n", rd_n, e_rd_n);
    chk(wr_n == e_wr_n, tag, "wr_n", wr_n, e_wr_n);
    chk(ad_oe == e_oe, tag, "ad_oe", ad_oe, e_oe);
    chk(req_ack == e_ack, tag, "req_ack", req_ack, e_ack);
  endtask

  // reference: which wait select applies (R5), how many strobe cycles (R4)
  function automatic int ref_code(input int a);
    if (cfg_limit == 0) return cfg_wait_lo;
    return (a >= cfg_limit * 32'h2000) ? cfg_wait_hi : cfg_wait_lo;
  endfunction

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    bus(tag, 0, 1, 1, 0, 0);
  endtask

  // called at a negedge; early=1 means the bridge is in its ack cycle
  task automatic access(input bit w, input int a, input logic [7:0] wd,
                        input logic [7:0] rb, input bit early, input string tg);
    int code, n;
    code = ref_code(a);
    n = (code == 0) ? 1 : (code == 1) ? 2 : 3;
    req_valid = 1'b1; req_write = w; req_addr = a[15:0]; req_wdata = wd;
    if (early) begin
      @(negedge clk);
      bus("R8", 0, 1, 1, 0, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (a < 32'h1100) begin
      bus("R9", 0, 1, 1, 0, 1);
      if (!w) chk(req_rdata == 8'h00, "R9", "rdata", req_rdata, 0);
      return;
    end
    bus("R2", 1, 1, 1, 1, 0);
    chk(ad_o == a[7:0], "R2", "ad_o", ad_o, a[7:0]);
    chk(a_hi == a[15:8], "R2", "a_hi", a_hi, a[15:8]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ad_i = rb + 8'(i);
      bus(tg, 0, w, !w, w, 0);
      if (w) chk(ad_o == wd, "R3", "ad_o", ad_o, wd);
      chk(a_hi == a[15:8], "R10", "a_hi", a_hi, a[15:8]);
    end
    if (code == 3) begin
      @(negedge clk);
      bus("R4", 0, 1, 1, 0, 0);
      chk(a_hi == a[15:8], "R4", "a_hi hold", a_hi, a[15:8]);
    end
    @(negedge clk);
    bus("R7", 0, 1, 1, 0, 1);
    if (!w) chk(req_rdata == rb + 8'(n - 1), "R6", "rdata", req_rdata, rb + 8'(n - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus("R1", 0, 1, 1, 0, 0);

    // limit 0: every address uses the lower select
    cfg_limit = 3'd0; cfg_wait_lo = 2'b10; cfg_wait_hi = 2'b00;
    access(1, 32'hF321, 8'hA5, 8'h00, 0, "R5"); idle_cycle("R7");
    cfg_wait_lo = 2'b00;
    access(0, 32'h1100, 8'h00, 8'h40, 0, "R9"); idle_cycle("R7");
    cfg_wait_lo = 2'b01;
    access(0, 32'h2345, 8'h00, 8'h50, 0, "R4"); idle_cycle("R7");
    cfg_wait_lo = 2'b11;
    access(1, 32'h7777, 8'h3C, 8'h00, 0, "R4"); idle_cycle("R7");
    access(0, 32'h8001, 8'h00, 8'h60, 0, "R4"); idle_cycle("R7");

    // split at 0x4000
    cfg_limit = 3'd2; cfg_wait_lo = 2'b00; cfg_wait_hi = 2'b11;
    access(0, 32'h3FFF, 8'h00, 8'h10, 0, "R5"); idle_cycle("R7");
    access(0, 32'h4000, 8'h00, 8'h20, 0, "R5"); idle_cycle("R7");
    // split at 0xE000
    cfg_limit = 3'd7; cfg_wait_lo = 2'b10; cfg_wait_hi = 2'b01;
    access(1, 32'hDFFF, 8'h11, 8'h00, 0, "R5"); idle_cycle("R7");
    access(0, 32'hE000, 8'h00, 8'h30, 0, "R5"); idle_cycle("R7");

    // below external base
    access(0, 32'h10FF, 8'h00, 8'h00, 0, "R9"); idle_cycle("R9");
    access(1, 32'h0000, 8'h99, 8'h00, 0, "R9"); idle_cycle("R9");

    // back to back: next request raised in the ack cycle
    access(0, 32'h9000, 8'h00, 8'h70, 0, "R3");
    access(1, 32'hE100, 8'h5A, 8'h00, 1, "R8");
    access(0, 32'h1234, 8'h00, 8'h80, 1, "R8");
    idle_cycle("R7");
    idle_cycle("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule